// File: doc/BRIEF.md
# Byte-Lane Bus Access Splitter

This block sits between a core's load/store port and a 16-bit external memory bus. The core hands it one request at a time: an address, a size flag (byte or word), a direction and write data. The block runs one or two bus cycles and then pulses a done strobe. For reads, the strobe carries the data right-aligned.

Every bus cycle presents an address whose bit 0 serves as the low-lane select. It also drives an active-low enable for the high byte lane, and it holds everything steady until the memory acknowledges. Even-address words move in a single cycle on both lanes. A byte goes on the lane picked by its address parity. An odd-address word is broken into two single-byte cycles: first the odd byte on the high lane, then the following even byte on the low lane. The block steers the write bytes onto the correct lanes and rebuilds the read word in little-endian order.

Only one access is in flight at a time. A new request is taken only once the previous access has been acknowledged for the last time.

Top module: `bytelane_splitter`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_cyc and done are 0 and req_ready is 1.
- R2: A word access at an even address uses one bus cycle at that address with bus_nbhe=0 and bus_addr[0]=0, both lanes active. Write data goes out unchanged, and read data is the full 16-bit bus word.
- R3: A byte access at an odd address uses one bus cycle with bus_nbhe=0 and bus_addr[0]=1, high lane only. The write byte req_wdata[7:0] is placed on bus_wdata[15:8]. A read returns {8'h00, bus_rdata[15:8]}.
- R4: A byte access at an even address uses one bus cycle with bus_nbhe=1 and bus_addr[0]=0, low lane only. The write byte is on bus_wdata[7:0], and a read returns {8'h00, bus_rdata[7:0]}.
- R5: A word access at odd address A uses exactly two bus cycles. The first is at A with bus_nbhe=0 (high lane). The second is at A+1 with bus_nbhe=1 and bus_addr[0]=0 (low lane). The combination bus_nbhe=1 with bus_addr[0]=1 is never driven during a bus cycle.
- R6: For a split read, rdata equals {low byte of the second cycle, high byte of the first cycle}.
- R7: For a split write, req_wdata[7:0] is on bus_wdata[15:8] in the first cycle, and req_wdata[15:8] is on bus_wdata[7:0] in the second.
- R8: While bus_cyc is high and bus_ack is low, bus_addr, bus_nbhe, bus_we and bus_wdata stay unchanged in the next cycle.
- R9: req_ready falls in the cycle after a request is accepted. Requests presented while it is low start no bus cycle and change no memory.
- R10: done is a one-cycle pulse in the cycle after the final bus_ack of an access.
- R11: An odd-address word at the top address wraps, so its second cycle is at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request strobe, taken when req_ready is high |
| req_addr | input | ADDR_W | Byte address of the access |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | BUS_W | Write data, right-aligned for bytes |
| req_ready | output | 1 | High when no access is in flight |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | BUS_W | Read result, valid with done |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_addr | output | ADDR_W | Bus address; bit 0 is the low-lane select (active low) |
| bus_nbhe | output | 1 | High-lane enable, active low |
| bus_we | output | 1 | Bus write strobe |
| bus_wdata | output | BUS_W | Bus write data; the unused lane repeats the active byte |
| bus_rdata | input | BUS_W | Bus read data, sampled with bus_ack |
| bus_ack | input | 1 | Memory acknowledge for the current bus cycle |

## Verification
The assertions assume the memory raises bus_ack only while bus_cyc is high. They also assume bus_ack falls in the cycle after the sampled acknowledge, because the block loads the next split cycle at that same edge. The bench's bus model enforces this: it always lowers its acknowledge for at least one cycle after each completed cycle, and it inserts zero to two wait states depending on address. The sweep covers every address of an 8-bit configuration in both sizes and both directions. It also holds a conflicting request on the core port during split accesses to exercise the busy rule.

// File: rtl/bls_pkg.sv
package bls_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

  function automatic logic needs_split(input logic word, input logic a0);
    return word & a0;
  endfunction

endpackage

// File: rtl/bls_beat_plan.sv
module bls_beat_plan #(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              word,
  input  logic              second,
  input  logic [BUS_W-1:0]  wdata,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_nbhe,
  output logic [BUS_W-1:0]  beat_wdata
);
  localparam int LANE_W = BUS_W / 2;

  logic [LANE_W-1:0] lo_byte;
  logic [LANE_W-1:0] hi_byte;

  assign lo_byte = wdata[LANE_W-1:0];
  assign hi_byte = wdata[BUS_W-1:LANE_W];

  // First beat: odd addresses use the high lane, even bytes the low lane.
  // Second beat of a split: following even byte on the low lane.
  always_comb begin
    beat_addr  = addr;
    beat_nbhe  = 1'b0;
    beat_wdata = {lo_byte, lo_byte};
    if (second) begin
      beat_addr  = addr + ADDR_W'(1);
      beat_nbhe  = 1'b1;
      beat_wdata = {hi_byte, hi_byte};
    end else if (word && !addr[0]) begin
      beat_wdata = wdata;
    end else if (!word && !addr[0]) begin
      beat_nbhe  = 1'b1;
    end
  end

endmodule

// File: rtl/bls_seq.sv
module bls_seq
  import bls_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_we,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              req_ready,
  output logic [ADDR_W-1:0] plan_addr,
  output logic              plan_word,
  output logic              plan_second,
  output logic [BUS_W-1:0]  plan_wdata,
  input  logic [ADDR_W-1:0] beat_addr,
  input  logic              beat_nbhe,
  input  logic [BUS_W-1:0]  beat_wdata,
  output logic              bus_cyc,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_nbhe,
  output logic              bus_we,
  output logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_ack,
  output logic              cap_word,
  output logic              cap_odd,
  output logic              first_ack,
  output logic              last_ack
);
  seq_state_e        state;
  logic              phase;
  logic [ADDR_W-1:0] cap_addr;
  logic [BUS_W-1:0]  cap_wdata;
  logic              cap_we;
  logic              beat_ack;

  assign req_ready = (state == SEQ_IDLE);
  assign cap_word  = cap_word_q;
  assign cap_odd   = cap_addr[0];

  logic cap_word_q;

  // While idle the planner sees the incoming request (first beat);
  // while busy it sees the captured request and builds the second beat.
  assign plan_addr   = (state == SEQ_BUSY) ? cap_addr   : req_addr;
  assign plan_word   = (state == SEQ_BUSY) ? cap_word_q : req_word;
  assign plan_wdata  = (state == SEQ_BUSY) ? cap_wdata  : req_wdata;
  assign plan_second = (state == SEQ_BUSY);

  assign beat_ack  = (state == SEQ_BUSY) && bus_ack;
  assign first_ack = beat_ack && !phase && needs_split(cap_word_q, cap_addr[0]);
  assign last_ack  = beat_ack && !first_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      phase      <= 1'b0;
      cap_addr   <= '0;
      cap_wdata  <= '0;
      cap_we     <= 1'b0;
      cap_word_q <= 1'b0;
      bus_cyc    <= 1'b0;
      bus_addr   <= '0;
      bus_nbhe   <= 1'b1;
      bus_we     <= 1'b0;
      bus_wdata  <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (req_valid) begin
            cap_addr   <= req_addr;
            cap_wdata  <= req_wdata;
            cap_we     <= req_we;
            cap_word_q <= req_word;
            phase      <= 1'b0;
            bus_cyc    <= 1'b1;
            bus_addr   <= beat_addr;
            bus_nbhe   <= beat_nbhe;
            bus_we     <= req_we;
            bus_wdata  <= beat_wdata;
            state      <= SEQ_BUSY;
          end
        end
        SEQ_BUSY: begin
          if (first_ack) begin
            phase     <= 1'b1;
            bus_addr  <= beat_addr;
            bus_nbhe  <= beat_nbhe;
            bus_we    <= cap_we;
            bus_wdata <= beat_wdata;
          end else if (last_ack) begin
            bus_cyc <= 1'b0;
            phase   <= 1'b0;
            state   <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R5: the lane combination with both enables off never appears on the bus
  assert_lane_code_R5: assert property (@(posedge clk) disable iff (rst)
    bus_cyc |-> !(bus_nbhe && bus_addr[0]));

  // R5: after the odd high-lane beat of a split word, the low-lane even beat follows
  assert_split_second_R5: assert property (@(posedge clk) disable iff (rst)
    (first_ack && bus_cyc && !bus_nbhe && bus_addr[0])
      |=> (bus_cyc && bus_nbhe && !bus_addr[0] && (bus_addr == $past(bus_addr) + ADDR_W'(1))));

  // R8: a waiting bus cycle keeps its address, lanes and data
  assert_hold_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_ack)
      |=> (bus_cyc && $stable(bus_addr) && $stable(bus_nbhe) && $stable(bus_we) && $stable(bus_wdata)));

  // R9: an accepted request drops ready and starts a bus cycle
  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |=> (bus_cyc && !req_ready));

endmodule

// File: rtl/bls_read_merge.sv
module bls_read_merge #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first_ack,
  input  logic             last_ack,
  input  logic             cap_word,
  input  logic             cap_odd,
  input  logic [BUS_W-1:0] bus_rdata,
  output logic [BUS_W-1:0] rdata,
  output logic             done
);
  localparam int LANE_W = BUS_W / 2;

  logic [LANE_W-1:0] held_lo;
  logic [LANE_W-1:0] lane_lo;
  logic [LANE_W-1:0] lane_hi;
  logic [BUS_W-1:0]  merged;

  assign lane_lo = bus_rdata[LANE_W-1:0];
  assign lane_hi = bus_rdata[BUS_W-1:LANE_W];

  always_comb begin
    case ({cap_word, cap_odd})
      2'b11:   merged = {lane_lo, held_lo};
      2'b10:   merged = bus_rdata;
      2'b01:   merged = {{LANE_W{1'b0}}, lane_hi};
      default: merged = {{LANE_W{1'b0}}, lane_lo};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_lo <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= last_ack;
      if (first_ack) held_lo <= lane_hi;
      if (last_ack)  rdata   <= merged;
    end
  end

endmodule

// File: rtl/bytelane_splitter.sv
module bytelane_splitter #(
  parameter int ADDR_W = 20,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_we,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [BUS_W-1:0]  rdata,
  output logic              bus_cyc,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_nbhe,
  output logic              bus_we,
  output logic [BUS_W-1:0]  bus_wdata,
  input  logic [BUS_W-1:0]  bus_rdata,
  input  logic              bus_ack
);
  logic [ADDR_W-1:0] plan_addr;
  logic              plan_word;
  logic              plan_second;
  logic [BUS_W-1:0]  plan_wdata;
  logic [ADDR_W-1:0] beat_addr;
  logic              beat_nbhe;
  logic [BUS_W-1:0]  beat_wdata;
  logic              cap_word;
  logic              cap_odd;
  logic              first_ack;
  logic              last_ack;

  bls_beat_plan #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_plan (
    .addr       (plan_addr),
    .word       (plan_word),
    .second     (plan_second),
    .wdata      (plan_wdata),
    .beat_addr  (beat_addr),
    .beat_nbhe  (beat_nbhe),
    .beat_wdata (beat_wdata)
  );

  bls_seq #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_word    (req_word),
    .req_we      (req_we),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .plan_addr   (plan_addr),
    .plan_word   (plan_word),
    .plan_second (plan_second),
    .plan_wdata  (plan_wdata),
    .beat_addr   (beat_addr),
    .beat_nbhe   (beat_nbhe),
    .beat_wdata  (beat_wdata),
    .bus_cyc     (bus_cyc),
    .bus_addr    (bus_addr),
    .bus_nbhe    (bus_nbhe),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_ack     (bus_ack),
    .cap_word    (cap_word),
    .cap_odd     (cap_odd),
    .first_ack   (first_ack),
    .last_ack    (last_ack)
  );

  bls_read_merge #(.BUS_W(BUS_W)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .first_ack (first_ack),
    .last_ack  (last_ack),
    .cap_word  (cap_word),
    .cap_odd   (cap_odd),
    .bus_rdata (bus_rdata),
    .rdata     (rdata),
    .done      (done)
  );

  // R10: completion is a single-cycle strobe
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: completion follows an acknowledged bus cycle that ended the access
  assert_done_after_ack_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(bus_cyc && bus_ack) && !bus_cyc && req_ready));

endmodule

// File: tb/bytelane_splitter_test.sv
module bytelane_splitter_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int BW = 16;
  localparam int MEM_N = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_word = 1'b0;
  logic          req_we = 1'b0;
  logic [BW-1:0] req_wdata = '0;
  logic          req_ready;
  logic          done;
  logic [BW-1:0] rdata;
  logic          bus_cyc;
  logic [AW-1:0] bus_addr;
  logic          bus_nbhe;
  logic          bus_we;
  logic [BW-1:0] bus_wdata;
  logic [BW-1:0] bus_rdata = '0;
  logic          bus_ack = 1'b0;

  bytelane_splitter #(.ADDR_W(AW), .BUS_W(BW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_word(req_word), .req_we(req_we), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata), .bus_cyc(bus_cyc),
    .bus_addr(bus_addr), .bus_nbhe(bus_nbhe), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0]    mem    [MEM_N];
  logic [7:0]    shadow [MEM_N];
  logic [AW-1:0] log_addr [4];
  logic          log_nbhe [4];
  logic [BW-1:0] log_wd   [4];
  int            log_n = 0;
  int            ack_cyc = 0;
  int            wait_n = 0;
  int            cnt = 0;
  bit            unstable = 1'b0;
  logic [AW-1:0] l_addr;
  logic          l_nbhe, l_we;
  logic [BW-1:0] l_wd;
  int            tests = 0;
  int            fails = 0;
  bit            finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bus memory model: lanes per the enable encoding of R2..R5.
  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 1'b0;
      cnt = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
      cnt = 0;
    end else if (bus_cyc) begin
      if (cnt == 0) begin
        l_addr = bus_addr; l_nbhe = bus_nbhe; l_we = bus_we; l_wd = bus_wdata;
        unstable = 1'b0;
      end else if (l_addr != bus_addr || l_nbhe != bus_nbhe || l_we != bus_we || l_wd != bus_wdata) begin
        unstable = 1'b1;
      end
      if (cnt == wait_n) begin
        chk(!unstable, "R8", "bus held during wait", int'(unstable), 0);
        chk(!(bus_nbhe && bus_addr[0]), "R5", "lane code", {bus_nbhe, bus_addr[0]}, 0);
        if (bus_we) begin
          if (!bus_addr[0]) mem[{bus_addr[AW-1:1], 1'b0}] = bus_wdata[7:0];
          if (!bus_nbhe)    mem[{bus_addr[AW-1:1], 1'b1}] = bus_wdata[15:8];
        end else begin
          bus_rdata = {mem[{bus_addr[AW-1:1], 1'b1}], mem[{bus_addr[AW-1:1], 1'b0}]};
        end
        if (log_n < 4) begin
          log_addr[log_n] = bus_addr; log_nbhe[log_n] = bus_nbhe; log_wd[log_n] = bus_wdata;
        end
        log_n++;
        ack_cyc = cyc;
        bus_ack = 1'b1;
      end else begin
        cnt++;
      end
    end
  end

  task automatic access(input logic [AW-1:0] a, input bit word, input bit we,
                        input logic [BW-1:0] wd, input bit junk);
    logic [AW-1:0] a1;
    bit split;
    bit mem_ok;
    string rq;
    int guard;
    a1 = a + 1'b1;
    split = word && a[0];
    wait_n = (junk) ? 2 : int'(a % 3);
    log_n = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_word = word; req_we = we; req_wdata = wd;
    @(negedge clk);
    chk(!req_ready, "R9", "ready after accept", int'(req_ready), 0);
    if (junk) begin
      req_addr = a + 8'd37; req_word = 1'b1; req_we = 1'b1; req_wdata = 16'hDEAD;
      @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    chk(done, "R10", "done seen", int'(done), 1);
    chk(cyc == ack_cyc + 1, "R10", "done latency", cyc - ack_cyc, 1);
    chk(log_n == (split ? 2 : 1), split ? (junk ? "R9" : "R5") : "R2", "bus cycle count", log_n, split ? 2 : 1);
    if (split) begin
      chk(log_addr[0] == a && !log_nbhe[0], "R5", "first beat", {log_nbhe[0], log_addr[0]}, {1'b0, a});
      chk(log_addr[1] == a1 && log_nbhe[1], "R5", "second beat", {log_nbhe[1], log_addr[1]}, {1'b1, a1});
      if (a == '1) chk(log_addr[1] == '0, "R11", "wrap address", log_addr[1], 0);
      if (we) begin
        chk(log_wd[0][15:8] == wd[7:0], "R7", "first write byte", log_wd[0][15:8], wd[7:0]);
        chk(log_wd[1][7:0] == wd[15:8], "R7", "second write byte", log_wd[1][7:0], wd[15:8]);
      end
    end else begin
      rq = word ? "R2" : (a[0] ? "R3" : "R4");
      chk(log_addr[0] == a && log_nbhe[0] == (!word && !a[0]), rq, "beat lanes",
          {log_nbhe[0], log_addr[0]}, {(!word && !a[0]), a});
      if (we) begin
        if (word)      chk(log_wd[0] == wd, rq, "write word", log_wd[0], wd);
        else if (a[0]) chk(log_wd[0][15:8] == wd[7:0], rq, "write high lane", log_wd[0][15:8], wd[7:0]);
        else           chk(log_wd[0][7:0] == wd[7:0], rq, "write low lane", log_wd[0][7:0], wd[7:0]);
      end
    end
    if (we) begin
      shadow[a] = wd[7:0];
      if (word) shadow[a1] = wd[15:8];
    end else begin
      rq = split ? "R6" : (word ? "R2" : (a[0] ? "R3" : "R4"));
      if (word) chk(rdata == {shadow[a1], shadow[a]}, rq, "read word", rdata, {shadow[a1], shadow[a]});
      else      chk(rdata == {8'h00, shadow[a]}, rq, "read byte", rdata, {8'h00, shadow[a]});
    end
    mem_ok = 1'b1;
    for (int i = 0; i < MEM_N; i++) if (mem[i] != shadow[i]) mem_ok = 1'b0;
    chk(mem_ok, junk ? "R9" : "R7", "memory image", int'(mem_ok), 1);
    @(negedge clk);
    chk(!done, "R10", "done width", int'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = 8'(i * 29 + 5);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(!bus_cyc && !done && req_ready, "R1", "reset outputs", {bus_cyc, done, req_ready}, 3'b001);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_cyc && !done && req_ready, "R1", "after reset", {bus_cyc, done, req_ready}, 3'b001);
    for (int we = 0; we < 2; we++)
      for (int w = 0; w < 2; w++)
        for (int a = 0; a < MEM_N; a++)
          access(8'(a), w[0], we[0], 16'(a * 517 + w * 91 + we * 13 + 7), 1'b0);
    access(8'h11, 1'b1, 1'b0, 16'h0000, 1'b1);
    access(8'h2B, 1'b1, 1'b1, 16'hA55A, 1'b1);
    access(8'hFF, 1'b1, 1'b0, 16'h0000, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule